// File: doc/BRIEF.md
# Associative Page Address Translator

This block maps a 24-bit virtual word address to a physical core frame. The address splits into a 9-bit line offset in its low bits and a 9-bit page number directly above the offset. The page number is compared in one cycle against every frame register. Each register holds the page that currently lives in its frame, together with a valid flag. A hit returns the frame index and the line offset, and marks the frame as used. A miss raises a fault interrupt and keeps the whole faulting address for the handler to read.

Requests arrive on a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold `req_addr` steady while `req_valid` is high and `req_ready` is low. `req_ready` is low in two cases: a fault is waiting for acknowledge, or the winning frame is locked for a transfer. The response comes out one cycle after acceptance as a single-cycle `rsp_valid` pulse with no back-pressure, so the consumer must always take it.

Software fills frame registers and sets or clears lock bits through plain load ports. It reads all use bits as one vector and clears them with a strobe, which lets replacement logic sample recent activity without losing hits.

Top module: `apt_translator`

## Requirements
- R1: The page number is `req_addr[17:9]` and the line offset is `req_addr[8:0]`. `rsp_line` returns the offset. Bits 23..18 have no effect on translation.
- R2: An accepted request gives exactly one `rsp_valid` pulse in the next cycle. On a match against a valid frame, `rsp_hit`=1 and `rsp_frame` is that frame's index.
- R3: When several valid frames hold the requested page, the lowest-index frame wins and `rsp_multi`=1 with the response. Otherwise `rsp_multi`=0.
- R4: A request that matches no valid frame gives `rsp_hit`=0. In the response cycle `fault_irq` rises and `fault_addr` holds the full 24-bit address. Both stay unchanged until `fault_ack`.
- R5: While `fault_irq` is high, `req_ready` is 0. A cycle with `fault_ack`=1 clears `fault_irq` at the next edge.
- R6: A request whose winning frame has its lock bit set sees `req_ready`=0 and gives no response. It proceeds once the lock is cleared. A frame's page may be rewritten while its lock bit stays set.
- R7: A hit sets the use bit of its frame at the acceptance edge, so `use_bits[rsp_frame]`=1 in the response cycle.
- R8: `use_clr` clears all use bits at the next edge, while `use_bits` still shows the old vector during the strobe cycle. A hit accepted at that same edge leaves its own bit set.
- R9: `ld_we` writes `ld_block` and `ld_valid` into frame `ld_frame`. A frame whose valid flag is 0 never matches. A lookup at the same edge as a write sees the old contents.
- R10: After reset all frames are invalid and unlocked, `use_bits`=0, `fault_irq`=0, `rsp_valid`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 24 | Virtual word address |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Translation found |
| rsp_multi | output | 1 | More than one frame matched |
| rsp_frame | output | 5 | Winning frame index |
| rsp_line | output | 9 | Line offset of the request |
| fault_irq | output | 1 | Page-fault interrupt, held until acknowledged |
| fault_addr | output | 24 | Address that missed |
| fault_ack | input | 1 | Acknowledge for the interrupt |
| ld_we | input | 1 | Write a frame register |
| ld_frame | input | 5 | Frame to write |
| ld_block | input | 9 | Page number to store |
| ld_valid | input | 1 | Valid flag to store |
| lk_we | input | 1 | Write a lock bit |
| lk_frame | input | 5 | Frame whose lock bit is written |
| lk_val | input | 1 | New lock value |
| use_bits | output | 32 | Use bit of every frame |
| use_clr | input | 1 | Clear all use bits |

## Verification
The bench loads duplicate pages into several frames. A priority encoder that picked the highest match, or that missed the duplicate, would return the wrong frame or drop `rsp_multi`. It locks a frame while rewriting its page and checks that requests stall and give no response. A design that only checked the lock after acceptance would complete the access early. The bench also puts a hit in the same cycle as a use-bit clear, and a page write in the same cycle as a lookup of that page. Wrong ordering at the edge would lose the use mark or translate against the new contents. It holds faults without acknowledge to catch an interrupt that drops early or a fault address that is overwritten.

// File: rtl/apt_pkg.sv
package apt_pkg;
  typedef enum logic [1:0] {
    LK_MISS   = 2'd0,
    LK_HIT    = 2'd1,
    LK_LOCKED = 2'd2
  } lookup_e;
endpackage

// File: rtl/apt_cam.sv
module apt_cam #(
  parameter int NFRAMES = 32,
  parameter int BLK_W   = 9,
  parameter int FW      = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [FW-1:0]      wr_frame,
  input  logic [BLK_W-1:0]   wr_block,
  input  logic               wr_valid,
  input  logic               lk_en,
  input  logic [FW-1:0]      lk_frame,
  input  logic               lk_val,
  input  logic [BLK_W-1:0]   key,
  output logic [NFRAMES-1:0] match,
  output logic [NFRAMES-1:0] lock_vec
);
  for (genvar g = 0; g < NFRAMES; g++) begin : g_entry
    logic [BLK_W-1:0] blk_q;
    logic             vld_q;
    logic             lck_q;
    logic             sel_wr;
    logic             sel_lk;

    assign sel_wr = wr_en && (wr_frame == FW'(g));
    assign sel_lk = lk_en && (lk_frame == FW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        blk_q <= '0;
        vld_q <= 1'b0;
        lck_q <= 1'b0;
      end else begin
        if (sel_wr) begin
          blk_q <= wr_block;
          vld_q <= wr_valid;
        end
        if (sel_lk) lck_q <= lk_val;
      end
    end

    assign match[g]    = vld_q && (blk_q == key);
    assign lock_vec[g] = lck_q;
  end
endmodule

// File: rtl/apt_prio.sv
module apt_prio #(
  parameter int N  = 32,
  parameter int FW = 5
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic          multi,
  output logic [FW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = FW'(i);
    end
  end

  assign any   = |req;
  assign multi = |(req & (req - N'(1)));
endmodule

// File: rtl/apt_use.sv
module apt_use #(
  parameter int N  = 32,
  parameter int FW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [FW-1:0] set_idx,
  input  logic          clr,
  output logic [N-1:0]  bits
);
  logic [N-1:0] bits_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic hit_g;
    assign hit_g = set_en && (set_idx == FW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bits_q[g] <= 1'b0;
      else if (hit_g) bits_q[g] <= 1'b1;
      else if (clr)   bits_q[g] <= 1'b0;
    end
  end

  assign bits = bits_q;
endmodule

// File: rtl/apt_translator.sv
module apt_translator
  import apt_pkg::*;
#(
  parameter int NFRAMES = 32,
  parameter int BLK_W   = 9,
  parameter int LINE_W  = 9,
  parameter int ADDR_W  = 24,
  localparam int FW     = $clog2(NFRAMES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_multi,
  output logic [FW-1:0]      rsp_frame,
  output logic [LINE_W-1:0]  rsp_line,
  output logic               fault_irq,
  output logic [ADDR_W-1:0]  fault_addr,
  input  logic               fault_ack,
  input  logic               ld_we,
  input  logic [FW-1:0]      ld_frame,
  input  logic [BLK_W-1:0]   ld_block,
  input  logic               ld_valid,
  input  logic               lk_we,
  input  logic [FW-1:0]      lk_frame,
  input  logic               lk_val,
  output logic [NFRAMES-1:0] use_bits,
  input  logic               use_clr
);
  logic [BLK_W-1:0]   key;
  logic [NFRAMES-1:0] match;
  logic [NFRAMES-1:0] lock_vec;
  logic               any_hit;
  logic               multi_hit;
  logic [FW-1:0]      win_idx;
  lookup_e            status;
  logic               accept;

  assign key = req_addr[LINE_W +: BLK_W];

  apt_cam #(.NFRAMES(NFRAMES), .BLK_W(BLK_W), .FW(FW)) u_cam (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ld_we),
    .wr_frame (ld_frame),
    .wr_block (ld_block),
    .wr_valid (ld_valid),
    .lk_en    (lk_we),
    .lk_frame (lk_frame),
    .lk_val   (lk_val),
    .key      (key),
    .match    (match),
    .lock_vec (lock_vec)
  );

  apt_prio #(.N(NFRAMES), .FW(FW)) u_prio (
    .req   (match),
    .any   (any_hit),
    .multi (multi_hit),
    .idx   (win_idx)
  );

  always_comb begin
    if (!any_hit)               status = LK_MISS;
    else if (lock_vec[win_idx]) status = LK_LOCKED;
    else                        status = LK_HIT;
  end

  assign req_ready = !fault_irq && (status != LK_LOCKED);
  assign accept    = req_valid && req_ready;

  apt_use #(.N(NFRAMES), .FW(FW)) u_use (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (accept && (status == LK_HIT)),
    .set_idx (win_idx),
    .clr     (use_clr),
    .bits    (use_bits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_frame <= '0;
      rsp_line  <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_hit   <= (status == LK_HIT);
        rsp_multi <= multi_hit;
        rsp_frame <= win_idx;
        rsp_line  <= req_addr[LINE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_irq  <= 1'b0;
      fault_addr <= '0;
    end else if (accept && (status == LK_MISS)) begin
      fault_irq  <= 1'b1;
      fault_addr <= req_addr;
    end else if (fault_ack) begin
      fault_irq  <= 1'b0;
    end
  end
endmodule

// File: rtl/apt_translator_chk.sv
module apt_translator_chk #(
  parameter int NFRAMES = 32,
  parameter int ADDR_W  = 24,
  parameter int FW      = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic [FW-1:0]      rsp_frame,
  input logic               fault_irq,
  input logic [ADDR_W-1:0]  fault_addr,
  input logic               fault_ack,
  input logic [NFRAMES-1:0] use_bits,
  input logic               use_clr,
  input logic [NFRAMES-1:0] lock_vec
);
  logic [NFRAMES-1:0] lock_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_d <= '0;
    else        lock_d <= lock_vec;
  end

  a_r2_rsp_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  a_r2_no_rsp_without_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);
  a_r4_miss_raises_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> fault_irq);
  a_r4_fault_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_irq && !fault_ack) |=> (fault_irq && $stable(fault_addr)));
  a_r5_stall_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault_irq |-> !req_ready);
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_irq && fault_ack) |=> !fault_irq);
  a_r6_no_locked_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> !lock_d[rsp_frame]);
  a_r7_use_marked: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> use_bits[rsp_frame]);
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (use_clr && !(req_valid && req_ready)) |=> (use_bits == '0));
endmodule

bind apt_translator apt_translator_chk #(.NFRAMES(NFRAMES), .ADDR_W(ADDR_W), .FW(FW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_frame  (rsp_frame),
  .fault_irq  (fault_irq),
  .fault_addr (fault_addr),
  .fault_ack  (fault_ack),
  .use_bits   (use_bits),
  .use_clr    (use_clr),
  .lock_vec   (lock_vec)
);

// File: tb/test_apt_translator.sv
module test_apt_translator;
  localparam int NF = 32;
  localparam int FW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req_valid = 0, req_ready;
  logic [23:0]   req_addr = '0;
  logic          rsp_valid, rsp_hit, rsp_multi;
  logic [FW-1:0] rsp_frame;
  logic [8:0]    rsp_line;
  logic          fault_irq;
  logic [23:0]   fault_addr;
  logic          fault_ack = 0;
  logic          ld_we = 0, ld_valid = 0;
  logic [FW-1:0] ld_frame = '0;
  logic [8:0]    ld_block = '0;
  logic          lk_we = 0, lk_val = 0;
  logic [FW-1:0] lk_frame = '0;
  logic [NF-1:0] use_bits;
  logic          use_clr = 0;

  apt_translator i_apt_translator (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_multi(rsp_multi), .rsp_frame(rsp_frame), .rsp_line(rsp_line),
    .fault_irq(fault_irq), .fault_addr(fault_addr), .fault_ack(fault_ack),
    .ld_we(ld_we), .ld_frame(ld_frame), .ld_block(ld_block), .ld_valid(ld_valid),
    .lk_we(lk_we), .lk_frame(lk_frame), .lk_val(lk_val),
    .use_bits(use_bits), .use_clr(use_clr)
  );

  int n_chk = 0, n_fail = 0;
  logic [8:0]    m_blk [NF];
  logic [NF-1:0] m_val = '0, m_lck = '0, m_use = '0;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic void ref_look(input logic [8:0] b, output bit hit, output bit multi,
                                   output int idx);
    int cnt = 0;
    idx = 0;
    for (int i = NF - 1; i >= 0; i--) if (m_val[i] && m_blk[i] == b) begin idx = i; cnt++; end
    hit = cnt > 0;
    multi = cnt > 1;
  endfunction

  task automatic wr(input int f, input logic [8:0] b, input bit v);
    @(negedge clk);
    ld_we = 1; ld_frame = FW'(f); ld_block = b; ld_valid = v;
    @(negedge clk);
    ld_we = 0;
    m_blk[f] = b; m_val[f] = v;
  endtask

  task automatic lock(input int f, input bit v);
    @(negedge clk);
    lk_we = 1; lk_frame = FW'(f); lk_val = v;
    @(negedge clk);
    lk_we = 0;
    m_lck[f] = v;
  endtask

  task automatic ack();
    @(negedge clk);
    fault_ack = 1;
    @(negedge clk);
    fault_ack = 0;
    chk(fault_irq == 1'b0, "R5 ack clears irq", 64'(fault_irq), 0);
  endtask

  task automatic access(input logic [23:0] a);
    bit h, mu, rdy;
    int ix;
    ref_look(a[17:9], h, mu, ix);
    rdy = !(h && m_lck[ix]);
    @(negedge clk);
    req_valid = 1; req_addr = a;
    #1;
    chk(req_ready == rdy, rdy ? "R2 ready" : "R6 locked stall", 64'(req_ready), 64'(rdy));
    if (!rdy || !req_ready) begin
      @(negedge clk);
      req_valid = 0;
      chk(rsp_valid == 1'b0, "R6 no response while locked", 64'(rsp_valid), 0);
      return;
    end
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid == 1'b1, "R2 rsp_valid", 64'(rsp_valid), 1);
    chk(rsp_hit == h, "R2 hit", 64'(rsp_hit), 64'(h));
    chk(rsp_line == a[8:0], "R1 line", 64'(rsp_line), 64'(a[8:0]));
    chk(rsp_multi == mu, "R3 multi", 64'(rsp_multi), 64'(mu));
    if (h) begin
      chk(rsp_frame == FW'(ix), "R3 frame", 64'(rsp_frame), 64'(ix));
      m_use[ix] = 1'b1;
      chk(use_bits == m_use, "R7 use bits", 64'(use_bits), 64'(m_use));
    end else begin
      chk(fault_irq == 1'b1, "R4 irq", 64'(fault_irq), 1);
      chk(fault_addr == a, "R4 fault_addr", 64'(fault_addr), 64'(a));
      ack();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    bit h, mu;
    int ix;
    logic [23:0] a;
    void'($urandom(32'h5eed));
    for (int i = 0; i < NF; i++) m_blk[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R10 reset state
    chk(req_ready == 1 && rsp_valid == 0, "R10 reset ready/valid", {req_ready, rsp_valid}, 2'b10);
    chk(fault_irq == 0 && use_bits == '0, "R10 reset irq/use", 64'(use_bits), 0);
    // R9 invalid frames never match even for page 0
    access(24'h000005);
    // R1 upper bits ignored
    wr(4, 9'h055, 1);
    access({6'h3F, 9'h055, 9'h1A2});
    access({6'h00, 9'h055, 9'h003});
    // R3 duplicate pages: lowest index wins
    wr(9, 9'h1AA, 1);
    wr(5, 9'h1AA, 1);
    access({6'h00, 9'h1AA, 9'h010});
    // R9 invalidating a frame removes it from matching
    wr(5, 9'h1AA, 0);
    access({6'h00, 9'h1AA, 9'h011});
    // R4 irq held without ack, stalls requests (R5)
    @(negedge clk);
    req_valid = 1; req_addr = 24'h0F0F0F;
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(fault_irq == 1 && fault_addr == 24'h0F0F0F, "R4 irq held", 64'(fault_addr), 64'h0F0F0F);
    req_valid = 1; req_addr = {6'h0, 9'h055, 9'h0};
    #1;
    chk(req_ready == 0, "R5 stall while fault pending", 64'(req_ready), 0);
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid == 0, "R5 no response while pending", 64'(rsp_valid), 0);
    ack();
    // R6 lock stall, rewrite under lock, then release
    lock(4, 1);
    access({6'h0, 9'h055, 9'h001});
    wr(4, 9'h066, 1);
    access({6'h0, 9'h066, 9'h002});
    lock(4, 0);
    access({6'h0, 9'h066, 9'h002});
    // R8 clear concurrent with a hit
    @(negedge clk);
    use_clr = 1; req_valid = 1; req_addr = {6'h0, 9'h1AA, 9'h0};
    #1;
    chk(use_bits == m_use, "R8 old vector during strobe", 64'(use_bits), 64'(m_use));
    @(negedge clk);
    use_clr = 0; req_valid = 0;
    m_use = '0; m_use[9] = 1'b1;
    chk(use_bits == m_use, "R8 hit survives clear", 64'(use_bits), 64'(m_use));
    // R9 write and lookup at the same edge: old contents
    @(negedge clk);
    ld_we = 1; ld_frame = 9; ld_block = 9'h0AB; ld_valid = 1;
    req_valid = 1; req_addr = {6'h0, 9'h1AA, 9'h0};
    @(negedge clk);
    ld_we = 0; req_valid = 0;
    chk(rsp_valid && rsp_hit && rsp_frame == 9, "R9 same-edge lookup sees old", 64'(rsp_frame), 9);
    m_blk[9] = 9'h0AB; m_use[9] = 1'b1;
    access({6'h0, 9'h1AA, 9'h0});
    access({6'h0, 9'h0AB, 9'h0});
    // Random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 9);
      if (op < 3) wr($urandom_range(0, NF - 1), 9'($urandom_range(0, 11)), $urandom_range(0, 5) != 0);
      else if (op == 3) lock($urandom_range(0, NF - 1), $urandom_range(0, 2) == 0);
      else begin
        a = {6'($urandom), 9'($urandom_range(0, 13)), 9'($urandom)};
        access(a);
      end
    end
    ref_look(9'h0, h, mu, ix);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule